// File: doc/BRIEF.md
# SDRAM Bank Configuration And Decode

This block holds the configuration state of an SDRAM controller and turns it into an address decode. Software reaches every register through two bus locations. One location holds a register index. The other reads or writes the register that the index selects. The registers are a global configuration word, a status word, two error status words, an error address, refresh and power-management settings, an ECC configuration word, an ECC error status word, and one configuration word per memory bank.

Each bank word packs three fields: a base address, a three-bit power-of-two size code and an enable bit. A bank takes part in the decode only while its own enable bit and the global enable are both set. For each system address presented, the block reports which bank is hit as a one-hot vector, a miss flag, and the byte offset of the address within that bank.

While the ECC error status word is nonzero, the block drives an interrupt.

Top module: `sdram_bank_cfg`

## Requirements
- R1: After reset, the registers read as follows. Refresh (index 0x30) reads 0x05F00000. Power-management (0x34) reads 0x07C00000. Config (0x20) reads 0x00800000. Every other index listed in these requirements reads 0.
- R2: A write with `reg_sel`=0 loads the index register, and a read with `reg_sel`=0 returns it. With `reg_sel`=1, a write changes the register that the index selects, and `reg_rdata` shows that register without delay.
- R3: A read of the timing index 0x80 returns 0xFFFFFFFF. A read of any index that is not defined also returns 0xFFFFFFFF. A write to an undefined index changes no register.
- R4: Writes are masked as follows. Refresh stores value AND 0x3FF80000. Power-management stores (value AND 0xF8000000) OR 0x07C00000. ECC config (0x94) stores value AND 0x00F00000. ECC error status (0x98) stores value AND 0xFFF0F000. The error address (0x10) stores the value unmasked.
- R5: The config word (0x20) stores value AND 0xFFE00000. When a write moves config bit 31 from 0 to 1, status (0x24) bit 31 is cleared. When a write moves it from 1 to 0, status bit 31 is set.
- R6: When a write moves config bit 30 from 0 to 1, status bit 30 is set. When a write moves it from 1 to 0, status bit 30 is cleared. Writes to the status index are ignored. All other status bits read 0.
- R7: The error status words at 0x00 and 0x08 are write-one-to-clear. Nothing sets them, so they read 0 after any write.
- R8: Bank n sits at index 0x40+4n and stores value AND 0xFFDEE001. In the stored word, bits 31:23 are the base address (base = bits 31:23 followed by 23 zero bits), bits 19:17 are the size code, and bit 0 is the enable.
- R9: A bank hits an address A when all of these hold: its enable bit is 1, config bit 31 is 1, its size code is not 7, and base <= A < base + (4 MiB << code). The upper bound is computed without wrapping.
- R10: When several banks hit, only the lowest-numbered one appears in `bank_hit`. `bank_miss` is 1 exactly when no bank hits. `bank_offset` is A minus the winning bank's base, and 0 on a miss.
- R11: `ecc_irq` is 1 exactly while the stored ECC error status word is nonzero.
- R12: The decode is combinational on `sys_addr`. A bank register write changes the decode from the clock edge that stores it onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the index location, 1 selects the data location |
| reg_wr | input | 1 | Write strobe for the selected location |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected location |
| sys_addr | input | 32 | System address to decode |
| bank_hit | output | NUM_BANKS | One-hot hit vector, lowest bank first |
| bank_miss | output | 1 | No enabled bank covers the address |
| bank_offset | output | 32 | Offset of the address inside the winning bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
A bank register write and an address lookup can fall in the same cycle. The bench holds `sys_addr` on a point covered by two overlapping banks, then disables the lower bank through a data write. It samples the hit vector and offset before the storing edge and again after it. The decode must still name the lower bank before the edge and the higher bank after it. The same idea applies to global enable edges: the decode is swept over 4096 addresses before and after the config write, and every result is compared with an arithmetic model of the range rule.

// File: rtl/sdram_bank_cfg.sv
module sdram_bank_cfg #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [31:0]          sys_addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 bank_miss,
  output logic [31:0]          bank_offset,
  output logic                 ecc_irq
);
  localparam logic [31:0] IX_ERR0  = 32'h00;
  localparam logic [31:0] IX_ERR1  = 32'h08;
  localparam logic [31:0] IX_EADR  = 32'h10;
  localparam logic [31:0] IX_CFG   = 32'h20;
  localparam logic [31:0] IX_STAT  = 32'h24;
  localparam logic [31:0] IX_RFSH  = 32'h30;
  localparam logic [31:0] IX_PWR   = 32'h34;
  localparam logic [31:0] IX_BANK  = 32'h40;
  localparam logic [31:0] IX_ECFG  = 32'h94;
  localparam logic [31:0] IX_ESTAT = 32'h98;

  localparam logic [31:0] M_CFG   = 32'hFFE0_0000;
  localparam logic [31:0] M_RFSH  = 32'h3FF8_0000;
  localparam logic [31:0] M_PWR   = 32'hF800_0000;
  localparam logic [31:0] F_PWR   = 32'h07C0_0000;
  localparam logic [31:0] M_BANK  = 32'hFFDE_E001;
  localparam logic [31:0] M_ECFG  = 32'h00F0_0000;
  localparam logic [31:0] M_ESTAT = 32'hFFF0_F000;
  localparam logic [32:0] UNIT    = 33'h0_0040_0000;

  logic [31:0] idx, err0, err1, eadr, cfg, rfsh, pwr, ecfg, estat;
  logic [1:0]  st;
  logic [31:0] bcr [NUM_BANKS];
  logic [NUM_BANKS-1:0] raw_hit;
  logic [31:0] cfg_nv;

  wire data_wr = reg_wr & reg_sel;
  assign cfg_nv = reg_wdata & M_CFG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      err0  <= '0;
      err1  <= '0;
      eadr  <= '0;
      cfg   <= 32'h0080_0000;
      st    <= '0;
      rfsh  <= 32'h05F0_0000;
      pwr   <= F_PWR;
      ecfg  <= '0;
      estat <= '0;
      for (int i = 0; i < NUM_BANKS; i++) bcr[i] <= '0;
    end else if (reg_wr && !reg_sel) begin
      idx <= reg_wdata;
    end else if (data_wr) begin
      case (idx)
        IX_ERR0:  err0  <= err0 & ~reg_wdata;
        IX_ERR1:  err1  <= err1 & ~reg_wdata;
        IX_EADR:  eadr  <= reg_wdata;
        IX_CFG: begin
          if (!cfg[31] && cfg_nv[31]) st[1] <= 1'b0;
          else if (cfg[31] && !cfg_nv[31]) st[1] <= 1'b1;
          if (cfg[30] != cfg_nv[30]) st[0] <= cfg_nv[30];
          cfg <= cfg_nv;
        end
        IX_RFSH:  rfsh  <= reg_wdata & M_RFSH;
        IX_PWR:   pwr   <= (reg_wdata & M_PWR) | F_PWR;
        IX_ECFG:  ecfg  <= reg_wdata & M_ECFG;
        IX_ESTAT: estat <= reg_wdata & M_ESTAT;
        default: ;
      endcase
      for (int i = 0; i < NUM_BANKS; i++)
        if (idx == IX_BANK + 32'(4 * i)) bcr[i] <= reg_wdata & M_BANK;
    end
  end

  always_comb begin
    if (!reg_sel) reg_rdata = idx;
    else begin
      case (idx)
        IX_ERR0:  reg_rdata = err0;
        IX_ERR1:  reg_rdata = err1;
        IX_EADR:  reg_rdata = eadr;
        IX_CFG:   reg_rdata = cfg;
        IX_STAT:  reg_rdata = {st, 30'b0};
        IX_RFSH:  reg_rdata = rfsh;
        IX_PWR:   reg_rdata = pwr;
        IX_ECFG:  reg_rdata = ecfg;
        IX_ESTAT: reg_rdata = estat;
        default:  reg_rdata = 32'hFFFF_FFFF;
      endcase
      for (int i = 0; i < NUM_BANKS; i++)
        if (idx == IX_BANK + 32'(4 * i)) reg_rdata = bcr[i];
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    wire [32:0] lo   = {1'b0, bcr[g][31:23], 23'b0};
    wire [32:0] span = UNIT << bcr[g][19:17];
    wire [32:0] a33  = {1'b0, sys_addr};
    assign raw_hit[g] = bcr[g][0] & cfg[31] & (bcr[g][19:17] != 3'd7)
                      & (a33 >= lo) & (a33 < lo + span);
  end

  assign bank_hit  = raw_hit & (~raw_hit + NUM_BANKS'(1));
  assign bank_miss = ~|raw_hit;
  assign ecc_irq   = |estat;

  always_comb begin
    bank_offset = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (raw_hit[i]) bank_offset = sys_addr - {bcr[i][31:23], 23'b0};
  end

  // R5
  cfg_on_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IX_CFG && reg_wdata[31] && !cfg[31]) |=> !st[1]);
  // R5
  cfg_off_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IX_CFG && !reg_wdata[31] && cfg[31]) |=> st[1]);
  // R6
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IX_STAT) |=> $stable(st));
  // R8
  bank0_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IX_BANK) |=> bcr[0] == ($past(reg_wdata) & M_BANK));
  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[31] |-> (bank_miss && bank_hit == '0));
  // R11
  ecc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IX_ESTAT && (reg_wdata & M_ESTAT) != 0) |=> ecc_irq);
endmodule

// File: tb/sdram_bank_cfg_test.sv
module sdram_bank_cfg_test;
  localparam int NB = 4;
  logic clk = 0, rst_n = 0, reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0, sys_addr = 0;
  logic [31:0] reg_rdata, bank_offset;
  logic [NB-1:0] bank_hit;
  logic bank_miss, ecc_irq;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] sh [NB];
  bit gen_on = 0;

  sdram_bank_cfg #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_addr(sys_addr),
    .bank_hit(bank_hit), .bank_miss(bank_miss), .bank_offset(bank_offset),
    .ecc_irq(ecc_irq));

  always #2 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic put(input logic s, input logic [31:0] v);
    @(negedge clk);
    reg_sel = s; reg_wr = 1; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic wreg(input logic [31:0] ix, input logic [31:0] v);
    put(0, ix); put(1, v);
  endtask

  task automatic rreg(input logic [31:0] ix, output logic [31:0] v);
    put(0, ix);
    @(negedge clk); reg_sel = 1; #1 v = reg_rdata;
  endtask

  task automatic rchk(input string r, input logic [31:0] ix, input logic [31:0] exp);
    logic [31:0] v;
    rreg(ix, v);
    chk(r, v, exp);
  endtask

  task automatic wbank(input int n, input logic [31:0] v);
    wreg(32'h40 + 32'(4 * n), v);
    sh[n] = v & 32'hFFDE_E001;
  endtask

  function automatic logic [35:0] model(input logic [31:0] a);
    logic [3:0] h; logic [31:0] off;
    h = 0; off = 0;
    for (int i = NB - 1; i >= 0; i--) begin
      logic [63:0] base, sz;
      base = {32'b0, sh[i][31:23], 23'b0};
      sz = 64'd4194304 << sh[i][19:17];
      if (sh[i][0] && gen_on && sh[i][19:17] != 3'd7 && {32'b0, a} >= base && {32'b0, a} < base + sz) begin
        h = 4'(1 << i); off = a - base[31:0];
      end
    end
    return {h, off};
  endfunction

  task automatic sweep(input string r);
    for (int k = 0; k < 4096; k++) begin
      logic [35:0] e;
      sys_addr = (32'(k) << 20) + 32'h123;
      #1;
      e = model(sys_addr);
      chk({r, " hit"}, 32'(bank_hit), 32'(e[35:32]));
      chk({r, " miss"}, 32'(bank_miss), 32'(e[35:32] == 0));
      chk({r, " off"}, bank_offset, e[31:0]);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NB; i++) sh[i] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    rchk("R1 refresh", 32'h30, 32'h05F00000);
    rchk("R1 power", 32'h34, 32'h07C00000);
    rchk("R1 config", 32'h20, 32'h00800000);
    foreach (sh[i]) rchk("R1 bank", 32'h40 + 32'(4 * i), 0);
    rchk("R1 status", 32'h24, 0);
    rchk("R1 ecc status", 32'h98, 0);
    chk("R1 ecc_irq", 32'(ecc_irq), 0);
    chk("R1 miss", 32'(bank_miss), 1);
    // R2 index readback
    put(0, 32'hDEAD_BEEF);
    @(negedge clk); reg_sel = 0; #1 chk("R2 index", reg_rdata, 32'hDEAD_BEEF);
    wreg(32'h10, 32'h1234_5678);
    rchk("R2 R4 error address", 32'h10, 32'h1234_5678);
    // R3 undefined indices
    wreg(32'h50, 32'hFFFF_FFFF);
    wreg(32'h80, 32'h1234_5678);
    for (int ix = 0; ix < 'h100; ix += 2) begin
      logic [31:0] e;
      case (ix)
        'h00, 'h08, 'h24, 'h40, 'h44, 'h48, 'h4C, 'h94, 'h98: e = 0;
        'h10: e = 32'h1234_5678;
        'h20: e = 32'h00800000;
        'h30: e = 32'h05F00000;
        'h34: e = 32'h07C00000;
        default: e = 32'hFFFF_FFFF;
      endcase
      rchk("R3 sweep", 32'(ix), e);
    end
    // R4 masks
    wreg(32'h30, 32'hFFFF_FFFF); rchk("R4 refresh", 32'h30, 32'h3FF80000);
    wreg(32'h34, 32'h0);         rchk("R4 power", 32'h34, 32'h07C00000);
    wreg(32'h34, 32'hFFFF_FFFF); rchk("R4 power ones", 32'h34, 32'hFFC00000);
    wreg(32'h94, 32'hFFFF_FFFF); rchk("R4 ecc cfg", 32'h94, 32'h00F00000);
    // R7 write-one-to-clear
    wreg(32'h00, 32'hFFFF_FFFF); rchk("R7 err0", 32'h00, 0);
    wreg(32'h08, 32'hFFFF_FFFF); rchk("R7 err1", 32'h08, 0);
    // R5 R6 config edges
    wreg(32'h20, 32'h8000_0000); rchk("R5 cfg", 32'h20, 32'h80000000);
    rchk("R5 enable", 32'h24, 0);
    wreg(32'h20, 32'h0000_0000); rchk("R5 disable", 32'h24, 32'h80000000);
    wreg(32'h20, 32'hFFFF_FFFF); rchk("R5 cfg mask", 32'h20, 32'hFFE00000);
    rchk("R6 set 30", 32'h24, 32'h40000000);
    wreg(32'h24, 32'hFFFF_FFFF); rchk("R6 status ro", 32'h24, 32'h40000000);
    wreg(32'h20, 32'h4000_0000); rchk("R6 hold 30", 32'h24, 32'hC0000000);
    wreg(32'h20, 32'h0000_0000); rchk("R6 clear 30", 32'h24, 32'h80000000);
    // R8 bank mask
    wbank(0, 32'hFFFF_FFFF); rchk("R8 bank mask", 32'h40, 32'hFFDEE001);
    // R9 R10 decode sweeps
    wbank(0, 32'h0002_0001);
    wbank(1, 32'h0080_0001);
    wbank(2, 32'h0006_0001);
    wbank(3, 32'h100E_0001);
    sweep("R9 global off");
    wreg(32'h20, 32'h8000_0000); gen_on = 1;
    sweep("R9 R10 overlap");
    wbank(3, 32'hFF84_0001);
    sweep("R9 top of space");
    wbank(3, 32'hFF84_0000);
    sweep("R9 bank off");
    // R12 same-cycle write and lookup
    sys_addr = 32'h0090_0000;
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = 32'h44;
    @(posedge clk); #1 reg_wr = 0;
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_wdata = 32'h0080_0000;
    #1 chk("R12 before edge", 32'(bank_hit), 32'h2);
    chk("R12 offset before", bank_offset, 32'h0010_0000);
    @(posedge clk); #1 reg_wr = 0;
    chk("R12 after edge", 32'(bank_hit), 32'h4);
    chk("R12 offset after", bank_offset, 32'h0090_0000);
    sh[1] = 32'h0080_0000;
    sweep("R10 after disable");
    // R11 ECC interrupt
    wreg(32'h98, 32'h000F_0FFF);
    #1 chk("R11 masked zero", 32'(ecc_irq), 0);
    rchk("R4 ecc status mask", 32'h98, 0);
    wreg(32'h98, 32'h0010_0000);
    #1 chk("R11 raise", 32'(ecc_irq), 1);
    rchk("R4 ecc status", 32'h98, 32'h00100000);
    wreg(32'h98, 0);
    #1 chk("R11 lower", 32'(ecc_irq), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule